// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Combiner

This block watches a wide set of general-purpose input pins, grouped in banks, and turns level transitions into sticky per-pin event flags. Each pin carries its own enable for rising transitions and for falling transitions. A pin whose direction bit marks it as an output never records an event. Software acknowledges events by writing ones into the bit positions it wants cleared, one bank per write.

The event flags are merged into three registered interrupt levels. Pin 0 and pin 1 each drive a line of their own, and every remaining pin of every bank shares the third line. A fixed, parameterised wake mask picks the input pins whose level changes raise a single-cycle wake pulse toward the power controller. Raw pins are brought into the clock domain by a multi-flop synchronizer. Detection stays suppressed until that pipeline holds valid data after reset, so pins that are already high when reset is released do not produce false events.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted and right after it, the status vector is all zero and irq_pin0, irq_pin1, irq_rest and wake_pulse are low.
- R2: A 0-to-1 change on raw pin p sets status[p] when rise_en[p] is 1 and dir_out[p] is 0 (0 = input, 1 = output). Otherwise the change leaves status[p] untouched.
- R3: A 1-to-0 change on raw pin p sets status[p] when fall_en[p] is 1 and dir_out[p] is 0. Otherwise the change leaves status[p] untouched.
- R4: A pin with dir_out[p] = 1 never sets its status bit, whatever its enables and level changes.
- R5: A status bit stays set until a clear write. A write with clr_valid = 1 and bank index clr_bank = b clears status[b*BANK_W + k] for each bit k that is 1 in clr_data. Bits of other banks are not affected.
- R6: When a new event and a clear of the same bit take effect on the same clock edge, the bit ends up set.
- R7: irq_pin0 equals status[0] and irq_pin1 equals status[1], each registered one cycle after the status bit.
- R8: irq_rest is the registered OR of status bits 2 through the last pin of the last bank.
- R9: A level change on an input pin (dir_out = 0) whose wake mask bit is 1 produces a wake_pulse high for exactly one cycle. The defaults are 0x8003FE1B for bank 0, 0x002001FC for bank 1, 0xEC080000 for bank 2 and 0x0012007F for bank 3, with bank b at status bits b*32 and up. A change on any other pin produces no pulse.
- R10: Raw pin levels that are present at reset release create no status bits and no wake pulse while the synchronizer fills.
- R11: A raw pin change sets its status bit on the third clock edge after the change, and changes the interrupt line on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_BANKS*BANK_W | Unsynchronized pin levels |
| dir_out | input | NUM_BANKS*BANK_W | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*BANK_W | Rising-transition enable per pin |
| fall_en | input | NUM_BANKS*BANK_W | Falling-transition enable per pin |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_bank | input | BIDX_W | Bank addressed by the clear |
| clr_data | input | BANK_W | Bits to clear in the addressed bank |
| status | output | NUM_BANKS*BANK_W | Sticky event flags |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Shared interrupt for all other pins |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a freshly detected event for the same bit. The synchronizer delay hides that edge from the ports. The stimulus changes a pin on a falling clock edge, counts two further falling edges, and then drives a one-cycle clear of that bit so it is sampled exactly when the event is stored. A second clear issued later must then remove the bit. The warm-up case is reached by holding pins high with all enables set while reset is released. Every pin is swept through all eight combinations of direction and enables.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
   localparam int unsigned DFLT_BANKS  = 4;
   localparam int unsigned DFLT_BANK_W = 32;
   localparam int unsigned DFLT_SYNC   = 2;
   // wake-capable pins, bank 3 in the upper word down to bank 0 in the lower word
   localparam logic [127:0] DFLT_WAKE  = {32'h0012_007F, 32'hEC08_0000,
                                          32'h0020_01FC, 32'h8003_FE1B};

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/gpio_sync_bank.sv
`timescale 1ns/1ps
module gpio_sync_bank #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] lvl
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_bank: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_sync_bank: W must be positive");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
module gpio_edge_bank #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  WAKE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         armed,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] dir_out,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic         clr_hit,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] status,
   output logic         wake_any
);
   logic [W-1:0] prev_q;
   logic [W-1:0] status_q;
   logic [W-1:0] is_in;
   logic [W-1:0] rose;
   logic [W-1:0] fell;
   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;

   always_comb begin
      is_in = ~dir_out;
      rose  = lvl & ~prev_q;
      fell  = ~lvl & prev_q;
      set_v = armed ? (((rose & rise_en) | (fell & fall_en)) & is_in) : '0;
      clr_v = clr_hit ? clr_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         status_q <= '0;
      end else begin
         prev_q   <= lvl;
         // new events override a clear of the same bit
         status_q <= (status_q & ~clr_v) | set_v;
      end
   end

   assign status   = status_q;
   assign wake_any = armed & (|((lvl ^ prev_q) & is_in & WAKE));

   // R5: without a clear, no set bit drops
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R4: newly set bits belong to pins that were inputs
   a_r4_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & $past(dir_out)) == '0));

   // R2: a bit set while the level is high needs its rising enable
   a_r2_rise_enable: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & $past(lvl) & ~$past(rise_en)) == '0));

   // R3: a bit set while the level is low needs its falling enable
   a_r3_fall_enable: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(lvl) & ~$past(fall_en)) == '0));
endmodule

// File: rtl/gpio_irq_combine.sv
`timescale 1ns/1ps
module gpio_irq_combine #(
   parameter int unsigned NB = 4,
   parameter int unsigned W  = 32,
   localparam int unsigned N = NB * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  status,
   input  logic [NB-1:0] wake_req,
   output logic          irq_pin0,
   output logic          irq_pin1,
   output logic          irq_rest,
   output logic          wake_pulse
);
   if (N < 3) begin : g_bad_size
      $error("gpio_irq_combine: at least three pins are needed");
   end

   logic rest_any;
   assign rest_any = |status[N-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pin0   <= 1'b0;
         irq_pin1   <= 1'b0;
         irq_rest   <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         irq_pin0   <= status[0];
         irq_pin1   <= status[1];
         irq_rest   <= rest_any;
         wake_pulse <= |wake_req;
      end
   end

   // R7: dedicated lines track their own bits one cycle later
   a_r7_pair_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_pin0 == $past(status[0])) && (irq_pin1 == $past(status[1]))));

   // R8: the shared line never rises while the other bits were all clear
   a_r8_rest_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rest) |-> $past(status[N-1:2] != '0));

   // R9: a wake pulse always traces back to a bank request
   a_r9_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(wake_req != '0));
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq #(
   parameter int unsigned NUM_BANKS   = gpio_edge_pkg::DFLT_BANKS,
   parameter int unsigned BANK_W      = gpio_edge_pkg::DFLT_BANK_W,
   parameter int unsigned SYNC_STAGES = gpio_edge_pkg::DFLT_SYNC,
   parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK = gpio_edge_pkg::DFLT_WAKE,
   localparam int unsigned NPINS  = NUM_BANKS * BANK_W,
   localparam int unsigned BIDX_W = gpio_edge_pkg::idx_width(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_raw,
   input  logic [NPINS-1:0]  dir_out,
   input  logic [NPINS-1:0]  rise_en,
   input  logic [NPINS-1:0]  fall_en,
   input  logic              clr_valid,
   input  logic [BIDX_W-1:0] clr_bank,
   input  logic [BANK_W-1:0] clr_data,
   output logic [NPINS-1:0]  status,
   output logic              irq_pin0,
   output logic              irq_pin1,
   output logic              irq_rest,
   output logic              wake_pulse
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_edge_irq: NUM_BANKS must be positive");
   end

   // warm-up: detection waits until synchronizer and previous-level register hold real data
   logic [SYNC_STAGES:0] prime_q;
   logic                 armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prime_q <= '0;
      else        prime_q <= {prime_q[SYNC_STAGES-1:0], 1'b1};
   end
   assign armed = prime_q[SYNC_STAGES];

   logic [NUM_BANKS-1:0] wake_req;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_W-1:0] lvl_b;
      logic              hit_b;

      assign hit_b = clr_valid && (clr_bank == BIDX_W'(b));

      gpio_sync_bank #(.W(BANK_W), .STAGES(SYNC_STAGES)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (pin_raw[b*BANK_W +: BANK_W]),
         .lvl   (lvl_b)
      );

      gpio_edge_bank #(.W(BANK_W), .WAKE(WAKE_MASK[b*BANK_W +: BANK_W])) i_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .armed    (armed),
         .lvl      (lvl_b),
         .dir_out  (dir_out[b*BANK_W +: BANK_W]),
         .rise_en  (rise_en[b*BANK_W +: BANK_W]),
         .fall_en  (fall_en[b*BANK_W +: BANK_W]),
         .clr_hit  (hit_b),
         .clr_data (clr_data),
         .status   (status[b*BANK_W +: BANK_W]),
         .wake_any (wake_req[b])
      );
   end

   gpio_irq_combine #(.NB(NUM_BANKS), .W(BANK_W)) i_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .status     (status),
      .wake_req   (wake_req),
      .irq_pin0   (irq_pin0),
      .irq_pin1   (irq_pin1),
      .irq_rest   (irq_rest),
      .wake_pulse (wake_pulse)
   );

   // R10: nothing is recorded before the pipeline is primed
   a_r10_warmup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> ((status == '0) && !wake_pulse));

   // R9: wake requests only arrive once armed
   a_r9_wake_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req != '0) |-> armed);
endmodule

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
   localparam int NP = 128;
   localparam logic [127:0] WMASK = 128'h0012007F_EC080000_002001FC_8003FE1B;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_raw = '0;
   logic [NP-1:0] dir_out = '0;
   logic [NP-1:0] rise_en = '0;
   logic [NP-1:0] fall_en = '0;
   logic          clr_valid = 1'b0;
   logic [1:0]    clr_bank = '0;
   logic [31:0]   clr_data = '0;
   logic [NP-1:0] status;
   logic          irq_pin0, irq_pin1, irq_rest, wake_pulse;

   int total = 0;
   int bad = 0;
   int wake_cnt = 0;
   int wake_exp = 0;
   logic [NP-1:0] m_st = '0;

   always #2.5 clk = ~clk;

   gpio_edge_irq i_gpio_edge_irq (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .dir_out(dir_out),
      .rise_en(rise_en), .fall_en(fall_en), .clr_valid(clr_valid),
      .clr_bank(clr_bank), .clr_data(clr_data), .status(status),
      .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_rest(irq_rest),
      .wake_pulse(wake_pulse)
   );

   always @(negedge clk) if (rst_n && wake_pulse) wake_cnt++;

   task automatic chk(input string req, input string what,
                      input logic [NP-1:0] act, input logic [NP-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "status", status, m_st);
      chk(req, "irq lines", NP'({irq_pin0, irq_pin1, irq_rest}),
          NP'({m_st[0], m_st[1], |m_st[NP-1:2]}));
      chk(req, "wake count", NP'(wake_cnt), NP'(wake_exp));
   endtask

   task automatic toggle(input int p);
      @(negedge clk);
      pin_raw[p] = ~pin_raw[p];
      if (!dir_out[p]) begin
         if (pin_raw[p] && rise_en[p])  m_st[p] = 1'b1;
         if (!pin_raw[p] && fall_en[p]) m_st[p] = 1'b1;
         if (WMASK[p]) wake_exp++;
      end
      repeat (5) @(negedge clk);
   endtask

   task automatic clear(input int bank, input logic [31:0] data);
      @(negedge clk);
      clr_valid = 1'b1;
      clr_bank  = 2'(bank);
      clr_data  = data;
      m_st[bank*32 +: 32] = m_st[bank*32 +: 32] & ~data;
      @(negedge clk);
      clr_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 / R10: pins high and all enables on across reset release
      pin_raw = '1;
      rise_en = '1;
      fall_en = '1;
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");
      repeat (8) @(negedge clk);
      check_all("R10 warm-up");
      // drop the pins with enables off: one shared wake pulse, no status
      rise_en = '0;
      fall_en = '0;
      @(negedge clk);
      pin_raw = '0;
      wake_exp++;
      repeat (5) @(negedge clk);
      check_all("R9 R4 mass drop");

      // R2 R3 R4 R7 R8 R9 R11: every pin, every direction/enable combination
      for (int p = 0; p < NP; p++) begin
         for (int cfg = 0; cfg < 8; cfg++) begin
            @(negedge clk);
            dir_out = '0; rise_en = '0; fall_en = '0;
            dir_out[p] = cfg[0];
            rise_en[p] = cfg[1];
            fall_en[p] = cfg[2];
            toggle(p);
            check_all("R2 R3 R4 R7 R8 R9");
            toggle(p);
            check_all("R2 R3 R4 R7 R8 R9");
            clear(p / 32, 32'hFFFF_FFFF);
            check_all("R5");
         end
      end

      // R11: exact latency of status and interrupt
      @(negedge clk);
      dir_out = '0; rise_en = '0; fall_en = '0;
      rise_en[0] = 1'b1;
      @(negedge clk);
      pin_raw[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11", "status before third edge", NP'(status[0]), NP'(0));
      @(negedge clk);
      chk("R11", "status at third edge", NP'(status[0]), NP'(1));
      chk("R11", "irq before fourth edge", NP'(irq_pin0), NP'(0));
      @(negedge clk);
      chk("R11", "irq at fourth edge", NP'(irq_pin0), NP'(1));
      m_st[0] = 1'b1;
      wake_exp++;
      repeat (3) @(negedge clk);
      check_all("R7 R11");
      clear(0, 32'h1);
      check_all("R5 R7");
      rise_en[0] = 1'b0;
      toggle(0);

      // R6: clear lands on the same edge that stores a new event
      @(negedge clk);
      rise_en[40] = 1'b1;
      @(negedge clk);
      pin_raw[40] = 1'b1;
      repeat (2) @(negedge clk);
      clr_valid = 1'b1;
      clr_bank  = 2'd1;
      clr_data  = 32'h0000_0100;
      @(negedge clk);
      clr_valid = 1'b0;
      m_st[40] = 1'b1;
      wake_exp++;
      repeat (4) @(negedge clk);
      check_all("R6 collision");
      // R5: clear of a different bank leaves it set, then its own bank clears it
      clear(2, 32'hFFFF_FFFF);
      check_all("R5 other bank");
      clear(1, 32'h0000_0100);
      check_all("R5 own bank");

      // R5: partial clear in bank 2 keeps the uncleared bit
      rise_en = '0;
      rise_en[64 + 3] = 1'b1;
      rise_en[64 + 9] = 1'b1;
      toggle(64 + 3);
      toggle(64 + 9);
      check_all("R5 two set");
      clear(2, 32'h0000_0008);
      check_all("R5 partial");
      clear(2, 32'h0000_0200);
      check_all("R5 rest");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule